// File: doc/BRIEF.md
# Debug Watchpoint Match Unit

The unit watches a core's memory and I/O traffic on behalf of a debugger. It holds a small set of address-compare slots and one packed control word. Software loads each slot's address through a register write port. In the control word it also sets, for each slot, a watched access type, a region length and two enable bits. Every cycle the unit is offered at most one access, described by its address, its size and its kind. Each slot compares that access against its own aligned region.

A match on an enabled slot sets that slot's bit in a sticky status vector. On the following cycle a one-cycle trap pulse is raised if any status bit went from clear to set. A task-switch strobe drops every per-task enable and keeps the enables that apply to all tasks. Reserved control bits always read as zero. Delivery of the debug exception is left to the surrounding core.

Write-port selects: 0 to 3 load the address of slot 0 to 3, 4 loads the control word, 5 writes the status vector, and 6 and 7 are ignored.

Top module: `dbg_watch_unit`

## Requirements
- R1: After a synchronous active-low reset, the control word, the status vector, the trap output and all slot addresses are zero.
- R2: A write to the control word (select 4) stores bits 0 to 9 and 16 to 31 as written and forces bits 10 to 15 to zero. Bits 8 and 9 (the exact-match flags) are kept but have no effect on matching.
- R3: Slot i has a per-task enable at control bit 2*i and an all-task enable at bit 2*i+1. Either bit enables the slot. A slot with both bits clear never matches, whatever its other settings.
- R4: The 4-bit field of slot i sits at control bits 16+4*i to 19+4*i. Its low two bits select the type and its high two bits select the length. Type 00 matches only fetches, 01 only writes, and 11 both reads and writes. Access kinds are 00 fetch, 01 write, 10 read and 11 I/O.
- R5: Length codes 00, 01, 11 and 10 mean 1, 2, 4 and 8 bytes. The region starts at the slot address with its low log2(length) bits cleared. An access of 2^acc_size bytes at acc_addr matches when its bytes overlap that region.
- R6: Length code 10 (8 bytes) is legal only when parameter LEN8_EN is 1. With LEN8_EN at 0, a slot using that code never matches.
- R7: Type 10 matches only I/O-kind accesses, and only while io_en is high.
- R8: Status bit i is set at the clock edge that samples a matching access on slot i. It stays set until a write to select 5 carries a zero in bit i. A cycle with acc_valid low sets nothing.
- R9: trap is high for exactly the one cycle after an edge at which some status bit went from clear to set. A match on a bit that is already set gives no pulse.
- R10: At the edge that samples task_switch high, every per-task enable bit is cleared and every all-task enable is kept. If the control word is written in the same cycle, the written value is stored with its per-task enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 slot address, 4 control, 5 status |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | An access is offered this cycle |
| acc_addr | input | ADDR_W | Access start address |
| acc_size | input | 2 | Access size, 2^acc_size bytes |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 I/O |
| io_en | input | 1 | Allows I/O-type slots to match |
| task_switch | input | 1 | Clears the per-task enables |
| ctrl_out | output | 32 | Current control word |
| status_out | output | NSLOT | Sticky per-slot match bits |
| trap | output | 1 | One-cycle pulse on a newly set status bit |

## Verification
Every result of this unit comes from a single register stage. A control or status write is visible in ctrl_out or status_out one edge after the strobe is sampled. A matching access sets its status bit at the edge that samples it, and trap goes high at that same edge for one cycle. The bench drives each stimulus just after a falling edge and holds it for one full period. It then samples at the next falling edge, half a period after the edge that was due to update the result. Before each swept access it clears the status vector, so the trap expected from any overlap is known exactly.

// File: rtl/dbgw_pkg.sv
// Package: shared encodings and helpers for the debug watchpoint match unit.
// Assumes at most four slots, so that all fields fit a 32-bit control word.
package dbgw_pkg;

    localparam int CTRL_W     = 32;
    localparam int FIELD_BASE = 16;
    localparam int FIELD_W    = 4;
    localparam int RSV_LO     = 10;
    localparam int RSV_HI     = 15;
    localparam int SEL_W      = 3;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

    // Kind of the access being offered.
    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_READ  = 2'b10,
        KIND_IO    = 2'b11
    } acc_kind_e;

    // Access type a slot watches.
    typedef enum logic [1:0] {
        WT_FETCH = 2'b00,
        WT_WRITE = 2'b01,
        WT_IO    = 2'b10,
        WT_RDWR  = 2'b11
    } watch_type_e;

    // Per-slot field: length in the high pair, type in the low pair.
    typedef struct packed {
        logic [1:0] len;
        logic [1:0] wtype;
    } slot_field_t;

    // log2 of the region length for a length code.
    function automatic logic [1:0] len_log2(input logic [1:0] code);
        case (code)
            2'b00:   len_log2 = 2'd0;
            2'b01:   len_log2 = 2'd1;
            2'b11:   len_log2 = 2'd2;
            default: len_log2 = 2'd3;
        endcase
    endfunction

    // Mask selecting the per-task enable bits of n slots.
    function automatic logic [CTRL_W-1:0] local_en_mask(input int n);
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[2*i] = 1'b1;
        return m;
    endfunction

    // Mask selecting the reserved control bits.
    function automatic logic [CTRL_W-1:0] reserved_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = RSV_LO; i <= RSV_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbgw_regs.sv
// Module: dbgw_regs
// Holds the slot address registers and the control word. Reserved control
// bits are forced low on write. A task switch clears the per-task enables
// after any same-cycle control write is applied.
// Assumes NSLOT <= 4 and ADDR_W <= 32.
module dbgw_regs
    import dbgw_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CTRL_W-1:0]             cfg_wdata,
    input  logic                          task_switch,
    output logic [NSLOT-1:0][ADDR_W-1:0]  slot_addr,
    output logic [CTRL_W-1:0]             ctrl_q
);

    localparam logic [CTRL_W-1:0] LOC_MASK = local_en_mask(NSLOT);
    localparam logic [CTRL_W-1:0] RSV_MASK = reserved_mask();

    logic [CTRL_W-1:0] ctrl_d;

    // Next control word: masked write, then per-task enable clear.
    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we && cfg_sel == SEL_CTRL) ctrl_d = cfg_wdata & ~RSV_MASK;
        if (task_switch)                   ctrl_d = ctrl_d & ~LOC_MASK;
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_addr
        // Address register of one slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr[g] <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(g))
                slot_addr[g] <= cfg_wdata[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/dbgw_slot_cmp.sv
// Module: dbgw_slot_cmp
// Combinational match for one slot: enable, type and length legality, and
// byte overlap of the access with the slot's aligned region. The arithmetic
// is one bit wider than the address, so regions at the top of the space
// do not wrap.
module dbgw_slot_cmp
    import dbgw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit LEN8_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] slot_addr,
    input  slot_field_t       field,
    input  logic [1:0]        en_pair,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              io_en,
    output logic              hit
);

    localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

    logic [1:0]        lg;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W:0]   reg_end;
    logic [ADDR_W:0]   acc_end;
    logic              overlap;
    logic              len_ok;
    logic              type_ok;

    // Region bounds and overlap test.
    always_comb begin
        lg      = len_log2(field.len);
        base    = slot_addr & ({ADDR_W{1'b1}} << lg);
        reg_end = {1'b0, base} + (ONE << lg);
        acc_end = {1'b0, acc_addr} + (ONE << acc_size);
        overlap = ({1'b0, acc_addr} < reg_end) && ({1'b0, base} < acc_end);
        len_ok  = LEN8_EN || (field.len != 2'b10);
    end

    // Type against access kind.
    always_comb begin
        case (watch_type_e'(field.wtype))
            WT_FETCH: type_ok = (acc_kind == KIND_FETCH);
            WT_WRITE: type_ok = (acc_kind == KIND_WRITE);
            WT_RDWR:  type_ok = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
            default:  type_ok = (acc_kind == KIND_IO) && io_en;
        endcase
    end

    assign hit = acc_valid && (|en_pair) && len_ok && overlap && type_ok;

endmodule

// File: rtl/dbgw_status.sv
// Module: dbgw_status
// Sticky per-slot status. A hit sets its bit. A status write clears the
// bits written as zero, and a hit in the same cycle wins. The trap flop
// pulses when any bit goes from clear to set.
module dbgw_status #(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] hit_vec,
    input  logic             clr_we,
    input  logic [NSLOT-1:0] clr_data,
    output logic [NSLOT-1:0] status_q,
    output logic             trap_q
);

    logic [NSLOT-1:0] kept;

    // Bits surviving a software write.
    assign kept = clr_we ? (status_q & clr_data) : status_q;

    // Status and trap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            trap_q   <= 1'b0;
        end else begin
            status_q <= kept | hit_vec;
            trap_q   <= |(hit_vec & ~status_q);
        end
    end

endmodule

// File: rtl/dbg_watch_unit.sv
// Module: dbg_watch_unit (top)
// Debug watchpoint match unit. It compares each offered access against
// NSLOT address slots that are configured through a packed control word,
// records matches in sticky status bits and pulses a trap.
// Assumes NSLOT <= 4 and ADDR_W <= 32. One access at most per cycle.
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int ADDR_W  = 32,
    parameter bit LEN8_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              io_en,
    input  logic              task_switch,
    output logic [31:0]       ctrl_out,
    output logic [NSLOT-1:0]  status_out,
    output logic              trap
);

    logic [NSLOT-1:0][ADDR_W-1:0] slot_addr;
    logic [CTRL_W-1:0]            ctrl_q;
    logic [NSLOT-1:0]             hit_vec;

    dbgw_regs #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .task_switch (task_switch),
        .slot_addr   (slot_addr),
        .ctrl_q      (ctrl_q)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        dbgw_slot_cmp #(.ADDR_W(ADDR_W), .LEN8_EN(LEN8_EN)) u_cmp (
            .slot_addr (slot_addr[g]),
            .field     (slot_field_t'(ctrl_q[FIELD_BASE+FIELD_W*g +: FIELD_W])),
            .en_pair   (ctrl_q[2*g +: 2]),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .acc_kind  (acc_kind),
            .io_en     (io_en),
            .hit       (hit_vec[g])
        );
    end

    dbgw_status #(.NSLOT(NSLOT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .clr_we   (cfg_we && cfg_sel == SEL_STAT),
        .clr_data (cfg_wdata[NSLOT-1:0]),
        .status_q (status_out),
        .trap_q   (trap)
    );

    assign ctrl_out = ctrl_q;

endmodule

// File: rtl/dbgw_checker.sv
// Module: dbgw_checker
// Port-level properties of the watchpoint unit, bound to the top module.
module dbgw_checker
    import dbgw_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic             acc_valid,
    input logic             task_switch,
    input logic [31:0]      ctrl_out,
    input logic [NSLOT-1:0] status_out,
    input logic             trap
);

    localparam logic [31:0] LOC_MASK = local_en_mask(NSLOT);
    localparam logic [31:0] GLB_MASK = LOC_MASK << 1;

    logic stat_wr;
    logic ctrl_wr;
    assign stat_wr = cfg_we && (cfg_sel == 3'd5);
    assign ctrl_wr = cfg_we && (cfg_sel == 3'd4);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_out[15:10] == 6'd0); // R2

    AST_TASK_CLEARS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> (ctrl_out & LOC_MASK) == 32'd0); // R10

    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !ctrl_wr) |=> (ctrl_out & GLB_MASK) == ($past(ctrl_out) & GLB_MASK)); // R10

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (status_out & $past(status_out)) == $past(status_out)); // R8

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !stat_wr) |=> status_out == $past(status_out)); // R8

    AST_TRAP_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $countones(status_out & ~$past(status_out)) != 0); // R9

    for (genvar g = 0; g < NSLOT; g++) begin : g_vac
        AST_VACANT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_out[2*g +: 2] == 2'b00) |=> !(status_out[g] && !$past(status_out[g]))); // R3
    end

endmodule

bind dbg_watch_unit dbgw_checker #(.NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .acc_valid   (acc_valid),
    .task_switch (task_switch),
    .ctrl_out    (ctrl_out),
    .status_out  (status_out),
    .trap        (trap)
);

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every type and length code of slot 1 against every access
// kind, size and a window of addresses, and compares with an arithmetic
// model. Directed cases cover reset, masking, enables, I/O gating, status
// stickiness, trap and task switch.
module dbg_watch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        io_en = 1'b1;
    logic        task_switch = 1'b0;
    logic [31:0] ctrl_out, ctrl_out4;
    logic [3:0]  status_out, status_out4;
    logic        trap, trap4;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    dbg_watch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .io_en(io_en),
        .task_switch(task_switch), .ctrl_out(ctrl_out),
        .status_out(status_out), .trap(trap)
    );

    // Same unit with the 8-byte length disabled.
    dbg_watch_unit #(.LEN8_EN(1'b0)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .io_en(io_en),
        .task_switch(task_switch), .ctrl_out(ctrl_out4),
        .status_out(status_out4), .trap(trap4)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_acc(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd, input bit v);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_size = sz; acc_kind = kd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Model of one slot from the requirements.
    function automatic bit exp_hit(input int ty, input int ln, input bit len8,
                                   input longint sa, input longint aa, input int sz,
                                   input int kd, input bit io);
        longint L, base, n;
        bit tok;
        L = (ln == 0) ? 1 : (ln == 1) ? 2 : (ln == 3) ? 4 : 8;
        if (ln == 2 && !len8) return 1'b0;
        base = sa - (sa % L);
        n = longint'(1) << sz;
        case (ty)
            0: tok = (kd == 0);
            1: tok = (kd == 1);
            3: tok = (kd == 1 || kd == 2);
            default: tok = (kd == 3) && io;
        endcase
        return tok && (aa < base + L) && (base < aa + n);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] cw;
        bit e, e4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ctrl_out == 0, "R1 ctrl", ctrl_out, 0);
        chk(status_out == 0, "R1 status", {28'd0, status_out}, 0);
        chk(trap == 0, "R1 trap", {31'd0, trap}, 0);
        // R1: slot addresses zero, so a fetch at 0 hits an enabled fetch slot 0
        wr(3'd4, 32'h0000_0001);
        do_acc(32'h0, 2'd0, 2'd0, 1'b1);
        chk(status_out == 4'b0001, "R1 addr", {28'd0, status_out}, 1);
        wr(3'd5, 0);

        // R2: reserved bits forced low, others kept
        wr(3'd4, 32'hFFFF_FFFF);
        chk(ctrl_out == 32'hFFFF_03FF, "R2 mask", ctrl_out, 32'hFFFF_03FF);
        wr(3'd4, 0);
        wr(3'd5, 0);

        // Sweep of slot 1 (R4 R5 R6 R7); bits 8/9 toggle with type for R2
        io_en = 1'b1;
        wr(3'd1, 32'h0000_1005);
        for (int ln = 0; ln < 4; ln++) begin
            for (int ty = 0; ty < 4; ty++) begin
                cw = 32'h4 | (32'(ln) << 22) | (32'(ty) << 20) | (((ty & 1) != 0) ? 32'h300 : 32'h0);
                wr(3'd4, cw);
                for (int kd = 0; kd < 4; kd++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        for (int off = 0; off < 32; off++) begin
                            wr(3'd5, 0);
                            do_acc(32'h0FF8 + 32'(off), 2'(sz), 2'(kd), 1'b1);
                            e  = exp_hit(ty, ln, 1'b1, 64'h1005, 64'h0FF8 + off, sz, kd, 1'b1);
                            e4 = exp_hit(ty, ln, 1'b0, 64'h1005, 64'h0FF8 + off, sz, kd, 1'b1);
                            chk(status_out == {2'b00, e, 1'b0}, "R4 R5 status",
                                {28'd0, status_out}, {30'd0, e, 1'b0});
                            chk(trap == e, "R9 trap", {31'd0, trap}, {31'd0, e});
                            chk(status_out4 == {2'b00, e4, 1'b0}, "R6 len8 off",
                                {28'd0, status_out4}, {30'd0, e4, 1'b0});
                        end
                    end
                end
            end
        end
        wr(3'd4, 0);
        wr(3'd5, 0);

        // R3: all-task enable only, slot 3 write watch of 4 bytes
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'h80 | (32'hD << 28));
        do_acc(32'h2002, 2'd0, 2'd1, 1'b1);
        chk(status_out == 4'b1000, "R3 global en", {28'd0, status_out}, 32'h8);
        chk(trap == 1'b1, "R9 trap new", {31'd0, trap}, 1);
        // R9: same hit again, bit already set
        do_acc(32'h2003, 2'd0, 2'd1, 1'b1);
        chk(trap == 1'b0, "R9 no trap", {31'd0, trap}, 0);
        // R8: write keeping bit 3, idle, valid-low access
        wr(3'd5, 32'hF);
        chk(status_out == 4'b1000, "R8 keep", {28'd0, status_out}, 32'h8);
        wr(3'd5, 0);
        chk(status_out == 4'b0000, "R8 clear", {28'd0, status_out}, 0);
        do_acc(32'h2000, 2'd2, 2'd1, 1'b0);
        chk(status_out == 4'b0000, "R8 valid low", {28'd0, status_out}, 0);
        chk(trap == 1'b0, "R8 valid low trap", {31'd0, trap}, 0);

        // R3: vacant slot 0 with a fetch field never matches
        wr(3'd0, 32'h0000_3000);
        wr(3'd4, 32'h0);
        do_acc(32'h3000, 2'd0, 2'd0, 1'b1);
        chk(status_out == 4'b0000, "R3 vacant", {28'd0, status_out}, 0);

        // R7: I/O slot 2 gated by io_en
        wr(3'd2, 32'h0000_0040);
        wr(3'd4, 32'h10 | (32'h2 << 24));
        io_en = 1'b0;
        do_acc(32'h40, 2'd0, 2'd3, 1'b1);
        chk(status_out == 4'b0000, "R7 io off", {28'd0, status_out}, 0);
        io_en = 1'b1;
        do_acc(32'h40, 2'd0, 2'd2, 1'b1);
        chk(status_out == 4'b0000, "R7 read kind", {28'd0, status_out}, 0);
        do_acc(32'h40, 2'd0, 2'd3, 1'b1);
        chk(status_out == 4'b0100, "R7 io on", {28'd0, status_out}, 32'h4);
        wr(3'd5, 0);

        // R10: task switch clears per-task enables only
        wr(3'd4, 32'h0000_00FF);
        @(negedge clk);
        task_switch = 1'b1;
        @(negedge clk);
        task_switch = 1'b0;
        chk(ctrl_out == 32'h0000_00AA, "R10 clear", ctrl_out, 32'hAA);
        // R10: same-cycle write and task switch
        @(negedge clk);
        task_switch = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0000_03FF;
        @(negedge clk);
        task_switch = 1'b0; cfg_we = 1'b0;
        chk(ctrl_out == 32'h0000_03AA, "R10 with write", ctrl_out, 32'h3AA);

        summary();
        $finish;
    end

endmodule